// File: doc/BRIEF.md
# Support and Reconstruction Handshake Controller

This block sequences two numerical engines that live outside it: a support-estimation engine and a reconstruction engine that first builds a pseudo-inverse and then reconstructs from buffered samples. An estimation state machine starts a support calculation and waits for the engine to report a valid support. It then holds that support until the reconstruction side accepts it, and parks until a change detector reports that the support has moved. A reconstruction state machine accepts each new support with a one-cycle acknowledge, starts a pseudo-inverse run and, once that run is done, reconstructs until a newer support arrives.

A change flag that arrives while a calculation or hand-over is still in flight is held in a sticky flag. It is served as soon as the estimation machine is parked again. Several such flags collapse into one recalculation. Alongside the control path, a first-in first-out sample store keeps buffering expanded samples for reconstruction. Its depth is a parameter, and any depth works, including non-power-of-two depths such as a working depth of 4294.

Top module: `supp_recon_ctrl`

## Requirements
- R1: While reset is held, `est_state` is 0, `rec_state` is 0, `est_start`, `supp_valid`, `supp_ack`, `pinv_start`, `recon_active`, `smp_rvalid` and `fifo_full` are low, and `fifo_empty` is high.
- R2: The estimation state codes are 0 init, 1 wait-ready, 2 calculate, 3 wait-acknowledge and 4 parked. The machine leaves code 0 after one cycle and stays in code 1 until `est_ready` is high. It then enters code 2, and `est_start` is high only during the first cycle spent in code 2.
- R3: In code 2 the machine stays until `est_valid` is high and then moves to code 3, where `supp_valid` is high.
- R4: The reconstruction state codes are 0 wait-support, 1 pseudo-inverse and 2 reconstruct. When `supp_valid` is seen in code 0, the next cycle shows code 1 with `supp_ack` and `pinv_start` each high for exactly that one cycle. The estimation machine moves from code 3 to code 4 on the following cycle.
- R5: In reconstruction code 1 the machine stays until `pinv_done` is high and then enters code 2, where `recon_active` is high.
- R6: In estimation code 4, a high `chg_flag` moves the machine to code 2 on the next cycle and raises `est_start`.
- R7: `chg_flag` pulses seen in estimation code 2 or 3 are remembered. The machine spends one cycle in code 4 and then returns to code 2 with `est_start`. Any number of such pulses causes exactly one recalculation.
- R8: In reconstruction code 2, a new `supp_valid` sends the machine back to code 1 with `supp_ack` and `pinv_start`. In code 1, `supp_valid` is not acknowledged.
- R9: A sample is stored when `smp_we` is high and the buffer is not full. A sample is read when `smp_oe` is high and the buffer is not empty. Read data appears on `smp_rdata` with `smp_rvalid` high one cycle after the read, in write order.
- R10: `fifo_full` rises after DEPTH stored samples. Writes while full are dropped, so exactly DEPTH samples come back out and `fifo_empty` then rises.
- R11: A read while empty leaves `smp_rvalid` low and `smp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| est_ready | input | 1 | Estimation engine ready |
| est_valid | input | 1 | Estimation engine reports a valid support |
| chg_flag | input | 1 | Support change from the change detector |
| pinv_done | input | 1 | Pseudo-inverse run finished |
| smp_we | input | 1 | Sample write enable |
| smp_wdata | input | DATA_W | Expanded sample to store |
| smp_oe | input | 1 | Sample read enable |
| est_start | output | 1 | Start pulse to the estimation engine |
| supp_valid | output | 1 | New support offered to the reconstruction side |
| supp_ack | output | 1 | Support accepted (one-cycle pulse) |
| pinv_start | output | 1 | Start pulse to the pseudo-inverse engine |
| recon_active | output | 1 | Reconstruction running |
| est_state | output | 3 | Estimation state code |
| rec_state | output | 2 | Reconstruction state code |
| smp_rdata | output | DATA_W | Sample read out |
| smp_rvalid | output | 1 | Read data valid |
| fifo_full | output | 1 | Sample store full |
| fifo_empty | output | 1 | Sample store empty |

## Verification
The hardest situation to reach from the ports is a support change that lands while the estimation machine is still busy and the reconstruction machine is already reconstructing. This case tests the sticky flag and the re-acknowledge path together. The stimulus pulses `chg_flag` twice during a calculation and then releases `est_valid`. It then checks for a single extra recalculation, and checks that a support offered during a pseudo-inverse run is only acknowledged after `pinv_done`. The sample store is driven past full and below empty, and a queue of expected samples checks every read.

// File: rtl/srh_pkg.sv
package srh_pkg;
  typedef enum logic [2:0] {
    E_INIT = 3'd0,
    E_WRDY = 3'd1,
    E_CALC = 3'd2,
    E_WDSP = 3'd3,
    E_IDLE = 3'd4
  } est_st_t;

  typedef enum logic [1:0] {
    R_WSUP  = 2'd0,
    R_PINV  = 2'd1,
    R_RECON = 2'd2
  } rec_st_t;
endpackage

// File: rtl/srh_est_fsm.sv
module srh_est_fsm
  import srh_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    eng_ready,
  input  logic    eng_valid,
  input  logic    chg,
  input  logic    ack,
  output est_st_t state_o,
  output logic    start_o,
  output logic    supp_valid_o
);
  est_st_t st_q, st_d;
  logic    pend_q, pend_d;
  logic    start_q, start_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      E_INIT:  st_d = E_WRDY;
      E_WRDY:  if (eng_ready)        st_d = E_CALC;
      E_CALC:  if (eng_valid)        st_d = E_WDSP;
      E_WDSP:  if (ack)              st_d = E_IDLE;
      E_IDLE:  if (chg || pend_q)    st_d = E_CALC;
      default: st_d = E_INIT;
    endcase
  end

  // change flags seen mid-calculation are held until the machine parks
  always_comb begin
    pend_d = pend_q;
    if (st_q == E_IDLE)
      pend_d = 1'b0;
    else if (chg && (st_q == E_CALC || st_q == E_WDSP))
      pend_d = 1'b1;
  end

  assign start_d = (st_d == E_CALC) && (st_q != E_CALC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_INIT;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end

  assign state_o      = st_q;
  assign start_o      = start_q;
  assign supp_valid_o = (st_q == E_WDSP);
endmodule

// File: rtl/srh_rec_fsm.sv
module srh_rec_fsm
  import srh_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    supp_valid,
  input  logic    pinv_done,
  output rec_st_t state_o,
  output logic    ack_o,
  output logic    pinv_start_o,
  output logic    recon_o
);
  rec_st_t st_q, st_d;
  logic    accept;
  logic    ack_q;

  assign accept = supp_valid && (st_q == R_WSUP || st_q == R_RECON);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      R_WSUP:  if (accept)    st_d = R_PINV;
      R_PINV:  if (pinv_done) st_d = R_RECON;
      R_RECON: if (accept)    st_d = R_PINV;
      default: st_d = R_WSUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= R_WSUP;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= accept;
    end
  end

  assign state_o      = st_q;
  assign ack_o        = ack_q;
  assign pinv_start_o = ack_q;
  assign recon_o      = (st_q == R_RECON);
endmodule

// File: rtl/srh_smp_fifo.sv
module srh_smp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         oe,
  output logic [W-1:0] rdata,
  output logic         rvalid,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_inc, rp_inc;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;
  logic [W-1:0]  rdata_q;
  logic          rvalid_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = we && !full;
  assign rd_ok = oe && !empty;

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wp_inc = wp_q + 1'b1;
      assign rp_inc = rp_q + 1'b1;
    end else begin : g_wrap
      assign wp_inc = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      assign rp_inc = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      if (wr_ok) wp_q <= wp_inc;
      if (rd_ok) begin
        rp_q    <= rp_inc;
        rdata_q <= mem[rp_q];
      end
      if (wr_ok && !rd_ok)      cnt_q <= cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/supp_recon_ctrl.sv
module supp_recon_ctrl
  import srh_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              est_ready,
  input  logic              est_valid,
  input  logic              chg_flag,
  input  logic              pinv_done,
  input  logic              smp_we,
  input  logic [DATA_W-1:0] smp_wdata,
  input  logic              smp_oe,
  output logic              est_start,
  output logic              supp_valid,
  output logic              supp_ack,
  output logic              pinv_start,
  output logic              recon_active,
  output logic [2:0]        est_state,
  output logic [1:0]        rec_state,
  output logic [DATA_W-1:0] smp_rdata,
  output logic              smp_rvalid,
  output logic              fifo_full,
  output logic              fifo_empty
);
  est_st_t est_st;
  rec_st_t rec_st;

  srh_est_fsm u_est (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_ready    (est_ready),
    .eng_valid    (est_valid),
    .chg          (chg_flag),
    .ack          (supp_ack),
    .state_o      (est_st),
    .start_o      (est_start),
    .supp_valid_o (supp_valid)
  );

  srh_rec_fsm u_rec (
    .clk          (clk),
    .rst_n        (rst_n),
    .supp_valid   (supp_valid),
    .pinv_done    (pinv_done),
    .state_o      (rec_st),
    .ack_o        (supp_ack),
    .pinv_start_o (pinv_start),
    .recon_o      (recon_active)
  );

  srh_smp_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (smp_we),
    .wdata  (smp_wdata),
    .oe     (smp_oe),
    .rdata  (smp_rdata),
    .rvalid (smp_rvalid),
    .full   (fifo_full),
    .empty  (fifo_empty)
  );

  assign est_state = est_st;
  assign rec_state = rec_st;
endmodule

// File: rtl/srh_chk.sv
module srh_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chg_flag,
  input logic              smp_we,
  input logic              smp_oe,
  input logic              est_start,
  input logic              supp_ack,
  input logic              pinv_start,
  input logic [2:0]        est_state,
  input logic [1:0]        rec_state,
  input logic [DATA_W-1:0] smp_rdata,
  input logic              smp_rvalid,
  input logic              fifo_full,
  input logic              fifo_empty
);
  AST_START_IN_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    est_start |-> est_state == 3'd2); // R2

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    supp_ack |=> !supp_ack); // R4

  AST_PINV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pinv_start |-> (rec_state == 2'd1 && $past(rec_state) != 2'd1)); // R4

  AST_IDLE_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (est_state == 3'd4 && chg_flag) |=> (est_state == 3'd2 && est_start)); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && smp_we && !smp_oe) |=> fifo_full); // R10

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R10

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && smp_oe) |=> (!smp_rvalid && $stable(smp_rdata))); // R11
endmodule

bind supp_recon_ctrl srh_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chg_flag   (chg_flag),
  .smp_we     (smp_we),
  .smp_oe     (smp_oe),
  .est_start  (est_start),
  .supp_ack   (supp_ack),
  .pinv_start (pinv_start),
  .est_state  (est_state),
  .rec_state  (rec_state),
  .smp_rdata  (smp_rdata),
  .smp_rvalid (smp_rvalid),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty)
);

// File: tb/tb_supp_recon_ctrl.sv
`timescale 1ns/100ps
module tb_supp_recon_ctrl;
  localparam int DW = 16;
  localparam int DEPTH = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic est_ready = 1'b0, est_valid = 1'b0, chg_flag = 1'b0, pinv_done = 1'b0;
  logic smp_we = 1'b0, smp_oe = 1'b0;
  logic [DW-1:0] smp_wdata = '0;
  logic est_start, supp_valid, supp_ack, pinv_start, recon_active;
  logic [2:0] est_state;
  logic [1:0] rec_state;
  logic [DW-1:0] smp_rdata;
  logic smp_rvalid, fifo_full, fifo_empty;

  int n_chk = 0;
  int n_fail = 0;
  int mcount = 0;
  logic [DW-1:0] expq[$];

  always #2 clk = ~clk;

  supp_recon_ctrl #(.DATA_W(DW), .BUF_DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // monitor: compares each read result against the expected queue
  always begin
    @(posedge clk);
    #1;
    if (rst_n && smp_rvalid) begin
      if (expq.size() == 0) chk("R9 unexpected read data", 1, 0);
      else chk("R9 read order", int'(smp_rdata), int'(expq.pop_front()));
    end
  end

  // driver tasks: push what a correct store must return
  task automatic xfer(input bit w, input bit r, input logic [DW-1:0] d);
    bit rok, wok;
    rok = r && (mcount > 0);
    wok = w && (mcount < DEPTH);
    smp_we = w; smp_oe = r; smp_wdata = d;
    if (wok) expq.push_back(d);
    mcount += int'(wok) - int'(rok);
    step();
    smp_we = 1'b0; smp_oe = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    step(); step();
    chk("R1 est_state", est_state, 0);
    chk("R1 rec_state", rec_state, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 outs", {est_start, supp_valid, supp_ack, pinv_start, recon_active, smp_rvalid}, 0);
    rst_n = 1'b1;
    step();
    chk("R2 wait-ready", est_state, 1);
    step(); step();
    chk("R2 holds without ready", est_state, 1);
    est_ready = 1'b1;
    step();
    chk("R2 calc", est_state, 2);
    chk("R2 start pulse", est_start, 1);
    step();
    chk("R3 stays in calc", est_state, 2);
    chk("R2 start single", est_start, 0);
    est_valid = 1'b1;
    step();
    est_valid = 1'b0;
    chk("R3 wait-ack", est_state, 3);
    chk("R3 supp_valid", supp_valid, 1);
    step();
    chk("R4 rec pinv", rec_state, 1);
    chk("R4 ack", supp_ack, 1);
    chk("R4 pinv_start", pinv_start, 1);
    step();
    chk("R4 est parked", est_state, 4);
    chk("R4 ack single", supp_ack, 0);
    chk("R4 pinv_start single", pinv_start, 0);
    step();
    chk("R5 waits for done", rec_state, 1);
    pinv_done = 1'b1;
    step();
    pinv_done = 1'b0;
    chk("R5 reconstruct", rec_state, 2);
    chk("R5 recon_active", recon_active, 1);
    step();
    chk("R6 parked", est_state, 4);
    chg_flag = 1'b1;
    step();
    chg_flag = 1'b0;
    chk("R6 recalc", est_state, 2);
    chk("R6 start", est_start, 1);
    // R7: two change pulses during the calculation
    step();
    chg_flag = 1'b1; step(); chg_flag = 1'b0; step();
    chg_flag = 1'b1; step(); chg_flag = 1'b0;
    chk("R7 still calc", est_state, 2);
    est_valid = 1'b1;
    step();
    est_valid = 1'b0;
    chk("R7 wait-ack", est_state, 3);
    step();
    chk("R8 back to pinv", rec_state, 1);
    chk("R8 ack from reconstruct", supp_ack, 1);
    step();
    chk("R7 parks one cycle", est_state, 4);
    step();
    chk("R7 pending served", est_state, 2);
    chk("R7 start", est_start, 1);
    step();
    chk("R7 start single", est_start, 0);
    est_valid = 1'b1;
    step();
    est_valid = 1'b0;
    chk("R7 wait-ack again", est_state, 3);
    step();
    chk("R8 no ack in pinv", supp_ack, 0);
    chk("R8 rec stays pinv", rec_state, 1);
    step();
    chk("R8 est holds", est_state, 3);
    pinv_done = 1'b1;
    step();
    pinv_done = 1'b0;
    chk("R8 reconstruct", rec_state, 2);
    step();
    chk("R8 late ack", supp_ack, 1);
    chk("R8 pinv again", rec_state, 1);
    step();
    chk("R7 parked", est_state, 4);
    step(); step();
    chk("R7 single recalc", est_state, 4);
    // sample store
    for (int i = 0; i < 5; i++) xfer(1'b1, 1'b0, DW'(16'h100 + i));
    chk("R9 not empty", fifo_empty, 0);
    for (int i = 0; i < 3; i++) xfer(1'b1, 1'b1, DW'(16'h200 + i));
    for (int i = 0; i < 5; i++) xfer(1'b0, 1'b1, '0);
    step();
    chk("R9 drained", fifo_empty, 1);
    chk("R9 all returned", expq.size(), 0);
    held = smp_rdata;
    xfer(1'b0, 1'b1, '0);
    chk("R11 no rvalid", smp_rvalid, 0);
    chk("R11 data held", int'(smp_rdata), int'(held));
    for (int i = 0; i < DEPTH; i++) xfer(1'b1, 1'b0, DW'(16'h3000 + i));
    chk("R10 full", fifo_full, 1);
    for (int i = 0; i < 3; i++) xfer(1'b1, 1'b0, DW'(16'h7700 + i));
    chk("R10 still full", fifo_full, 1);
    for (int i = 0; i < DEPTH; i++) xfer(1'b0, 1'b1, '0);
    step();
    chk("R10 empty after depth reads", fifo_empty, 1);
    chk("R10 queue drained", expq.size(), 0);
    held = smp_rdata;
    xfer(1'b0, 1'b1, '0);
    chk("R11 empty read", smp_rvalid, 0);
    chk("R11 data held", int'(smp_rdata), int'(held));
    step();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule